// File: doc/BRIEF.md
# Depth-First Subgraph Mapping Search Engine

This block decides whether a small pattern graph can be embedded in a larger target graph. The embedding must be one-to-one on vertices and must preserve every pattern edge. After a start pulse it captures both adjacency matrices and both vertex counts. It then binds pattern vertex 0, then vertex 1, and so on, each to a free target vertex. It tries candidates in ascending order and steps back one level whenever a level has no candidates left. When every pattern vertex is bound, a built-in leaf test checks that all pattern edges are preserved.

An external pruning unit can watch each search node through a probe. The probe is a valid strobe, the node's level and the partial mapping. The pruning unit answers on a prune-ok input in the same cycle. A low answer discards the node and its whole subtree. The result holds until the next accepted start. The result is a done flag, a found flag and, when found, the mapping itself.

Top module: `sgi_search_engine`

## Requirements
- R1: After reset, done, found and busy are 0 and map_vec is all zeros.
- R2: At every evaluated node, the candidate at the current level is below the captured target count and differs from every candidate at a lower level.
- R3: Pattern edge {i,j} is pattern_adj bit i*PA+j, and target edge {i,j} is target_adj bit i*PB+j; both matrices are symmetric. found rises only with done, and only for a complete mapping that takes every pattern edge to a target edge. Field k of map_vec (bits k*CW upward, CW bits wide) is the target vertex bound to pattern vertex k.
- R4: Candidates are tried in ascending target order at each level, with level 0 most significant. The reported mapping is therefore the lexicographically smallest valid one.
- R5: With prune_ok held high and no valid mapping, the search visits exactly tgt_n!/(tgt_n-pat_n)! leaf nodes and then ends with done=1 and found=0.
- R6: If pat_n exceeds tgt_n, done=1 and found=0 appear in the cycle right after start, and busy never rises.
- R7: A node at which prune_ok is low is abandoned together with its subtree, and the next candidate at the same level is tried. This holds at the leaf level too, so a leaf with prune_ok low is never accepted.
- R8: While busy is high, start is ignored. The search runs on unchanged, and busy and done are never high together.
- R9: Once done is high, it stays high with found and map_vec unchanged until the next start.
- R10: A pattern with zero vertices reports done=1 and found=1 in the cycle right after start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| pat_n | input | CW | Pattern vertex count (0..PA) |
| tgt_n | input | CW | Target vertex count (0..PB) |
| pat_adj | input | PA*PA | Pattern adjacency matrix |
| tgt_adj | input | PB*PB | Target adjacency matrix |
| prune_ok | input | 1 | Pruning unit's verdict on the node shown on the probe |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid |
| found | output | 1 | A valid mapping exists |
| probe_valid | output | 1 | A node is being evaluated this cycle |
| probe_level | output | LW | Level of the node on the probe |
| map_vec | output | PA*CW | Current or final mapping, one field per pattern vertex |

## Verification
The checker watches every node the engine evaluates. At each one it confirms that the fresh candidate is in range and unused by lower levels. It also confirms that found never stands without done, that done and busy exclude each other, and that a finished result stays frozen until a new start. Some properties need a whole search to be observed, and only the bench's scenarios show them. These are the order in which candidates are tried, the exact number of leaves an exhaustive search visits, whether the reported mapping is the smallest valid one, and how pruning at level 0 or at the leaves changes the outcome. Those scenarios are checked against a brute-force reference model.

// File: rtl/sgi_pkg.sv
// Shared types for the subgraph mapping search engine.
package sgi_pkg;

    // Controller phases: idle, choose the next candidate, evaluate a node.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_NODE = 2'd2
    } sgi_state_t;

endpackage

// File: rtl/sgi_next_free.sv
// Finds the lowest target vertex index that is unused, not below `from`
// and below `limit`.
// Assumes limit <= PB. Purely combinational.
module sgi_next_free #(
    parameter int PB = 8,
    parameter int CW = 4
) (
    input  logic [PB-1:0] used,
    input  logic [CW-1:0] from,
    input  logic [CW-1:0] limit,
    output logic          hit,
    output logic [CW-1:0] idx
);

    logic [PB-1:0] elig;

    // One eligibility term per target vertex.
    for (genvar k = 0; k < PB; k++) begin : g_elig
        assign elig[k] = !used[k] && (CW'(k) >= from) && (CW'(k) < limit);
    end

    // Priority pick: the lowest eligible index wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = PB - 1; k >= 0; k--) begin
            if (elig[k]) begin
                hit = 1'b1;
                idx = CW'(k);
            end
        end
    end

endmodule

// File: rtl/sgi_leaf_check.sv
// Leaf test: every pattern edge among the first pat_n vertices must map to
// a target edge under map_flat.
// Assumes bound fields hold values below PB. Combinational.
module sgi_leaf_check #(
    parameter int PA = 6,
    parameter int PB = 8,
    parameter int CW = 4
) (
    input  logic [PA*PA-1:0] pat_adj,
    input  logic [PB*PB-1:0] tgt_adj,
    input  logic [PA*CW-1:0] map_flat,
    input  logic [CW-1:0]    pat_n,
    output logic             ok
);

    localparam int AW = (PB > 1) ? $clog2(PB * PB) : 1;

    logic [PA*PA-1:0] viol;

    // One violation term per unordered pattern vertex pair.
    for (genvar i = 0; i < PA; i++) begin : g_row
        for (genvar j = 0; j < PA; j++) begin : g_col
            if (i < j) begin : g_pair
                logic [CW-1:0] vi;
                logic [CW-1:0] vj;
                logic [AW-1:0] tix;
                assign vi  = map_flat[i*CW +: CW];
                assign vj  = map_flat[j*CW +: CW];
                assign tix = AW'(vi * PB + vj);
                assign viol[i*PA+j] = (CW'(j) < pat_n) && pat_adj[i*PA+j]
                                      && !tgt_adj[tix];
            end else begin : g_none
                assign viol[i*PA+j] = 1'b0;
            end
        end
    end

    assign ok = ~|viol;

endmodule

// File: rtl/sgi_search_engine.sv
// Depth-first search for a one-to-one, edge-preserving mapping of a pattern
// graph into a target graph. Level k binds pattern vertex k. Candidates are
// tried in ascending order, and an exhausted level steps back. Each node is
// shown on the probe for one cycle, when prune_ok is sampled.
// Assumes pat_n <= PA, tgt_n <= PB and symmetric adjacency matrices.
// Inputs are captured on an accepted start.
module sgi_search_engine
    import sgi_pkg::*;
#(
    parameter int PA = 6,
    parameter int PB = 8,
    localparam int CW = $clog2(((PA > PB) ? PA : PB) + 1),
    localparam int LW = (PA > 1) ? $clog2(PA) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    pat_n,
    input  logic [CW-1:0]    tgt_n,
    input  logic [PA*PA-1:0] pat_adj,
    input  logic [PB*PB-1:0] tgt_adj,
    input  logic             prune_ok,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic             probe_valid,
    output logic [LW-1:0]    probe_level,
    output logic [PA*CW-1:0] map_vec
);

    localparam int TW = (PB > 1) ? $clog2(PB) : 1;

    sgi_state_t       state_q;
    logic [CW-1:0]    pat_n_q;
    logic [CW-1:0]    tgt_n_q;
    logic [PA*PA-1:0] pat_adj_q;
    logic [PB*PB-1:0] tgt_adj_q;
    logic [PB-1:0]    used_q;
    logic [LW-1:0]    lvl_q;
    logic [CW-1:0]    scan_q;
    logic [CW-1:0]    cand_q [PA];
    logic             done_q;
    logic             found_q;

    logic [PA*CW-1:0] map_flat;
    logic [CW-1:0]    cur_v;
    logic [CW-1:0]    prev_v;
    logic             at_leaf;
    logic             pick_hit;
    logic [CW-1:0]    pick_idx;
    logic             leaf_ok;

    // Flatten the per-level candidates into one vector.
    for (genvar k = 0; k < PA; k++) begin : g_map
        assign map_flat[k*CW +: CW] = cand_q[k];
    end

    // Current and parent-level candidates, and the leaf-level flag.
    assign cur_v   = cand_q[lvl_q];
    assign prev_v  = cand_q[lvl_q - 1'b1];
    assign at_leaf = (CW'(lvl_q) == (pat_n_q - 1'b1));

    sgi_next_free #(.PB(PB), .CW(CW)) u_next_free (
        .used  (used_q),
        .from  (scan_q),
        .limit (tgt_n_q),
        .hit   (pick_hit),
        .idx   (pick_idx)
    );

    sgi_leaf_check #(.PA(PA), .PB(PB), .CW(CW)) u_leaf_check (
        .pat_adj  (pat_adj_q),
        .tgt_adj  (tgt_adj_q),
        .map_flat (map_flat),
        .pat_n    (pat_n_q),
        .ok       (leaf_ok)
    );

    // Search controller: capture, pick, evaluate, backtrack and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pat_n_q   <= '0;
            tgt_n_q   <= '0;
            pat_adj_q <= '0;
            tgt_adj_q <= '0;
            used_q    <= '0;
            lvl_q     <= '0;
            scan_q    <= '0;
            done_q    <= 1'b0;
            found_q   <= 1'b0;
            for (int k = 0; k < PA; k++) begin
                cand_q[k] <= '0;
            end
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pat_n_q   <= pat_n;
                        tgt_n_q   <= tgt_n;
                        pat_adj_q <= pat_adj;
                        tgt_adj_q <= tgt_adj;
                        used_q    <= '0;
                        lvl_q     <= '0;
                        scan_q    <= '0;
                        found_q   <= 1'b0;
                        if (pat_n > tgt_n) begin
                            done_q <= 1'b1;
                        end else if (pat_n == '0) begin
                            done_q  <= 1'b1;
                            found_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= ST_PICK;
                        end
                    end
                end
                ST_PICK: begin
                    if (pick_hit) begin
                        cand_q[lvl_q]              <= pick_idx;
                        used_q[pick_idx[TW-1:0]]   <= 1'b1;
                        state_q                    <= ST_NODE;
                    end else if (lvl_q == '0) begin
                        done_q  <= 1'b1;
                        found_q <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        lvl_q                  <= lvl_q - 1'b1;
                        used_q[prev_v[TW-1:0]] <= 1'b0;
                        scan_q                 <= prev_v + 1'b1;
                    end
                end
                ST_NODE: begin
                    if (prune_ok && at_leaf && leaf_ok) begin
                        done_q  <= 1'b1;
                        found_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (prune_ok && !at_leaf) begin
                        lvl_q   <= lvl_q + 1'b1;
                        scan_q  <= '0;
                        state_q <= ST_PICK;
                    end else begin
                        used_q[cur_v[TW-1:0]] <= 1'b0;
                        scan_q                <= cur_v + 1'b1;
                        state_q               <= ST_PICK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign found       = found_q;
    assign probe_valid = (state_q == ST_NODE);
    assign probe_level = lvl_q;
    assign map_vec     = map_flat;

endmodule

// File: rtl/sgi_search_checker.sv
// Protocol and invariant checks for sgi_search_engine, bound to every instance.
// Assumes the captured target count is brought in as tgt_lim.
module sgi_search_checker #(
    parameter int PA = 6,
    parameter int PB = 8,
    localparam int CW = $clog2(((PA > PB) ? PA : PB) + 1),
    localparam int LW = (PA > 1) ? $clog2(PA) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             found,
    input logic             probe_valid,
    input logic [LW-1:0]    probe_level,
    input logic [PA*CW-1:0] map_vec,
    input logic [CW-1:0]    tgt_lim
);

    logic [CW-1:0] cur;
    logic          dup;

    // Candidate shown at the probed level.
    always_comb begin
        cur = '0;
        for (int k = 0; k < PA; k++) begin
            if (LW'(k) == probe_level) cur = map_vec[k*CW +: CW];
        end
    end

    // Does any lower level already hold that candidate?
    always_comb begin
        dup = 1'b0;
        for (int k = 0; k < PA; k++) begin
            if ((LW'(k) < probe_level) && (map_vec[k*CW +: CW] == cur)) dup = 1'b1;
        end
    end

    assert_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> !dup)
        else $error("R2: target vertex bound twice");

    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> (cur < tgt_lim))
        else $error("R2: candidate out of range");

    assert_found_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done)
        else $error("R3: found without done");

    assert_busy_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done)
        else $error("R8: busy and done together");

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(found) && $stable(map_vec)))
        else $error("R9: result changed while held");

endmodule

bind sgi_search_engine sgi_search_checker #(.PA(PA), .PB(PB)) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .found       (found),
    .probe_valid (probe_valid),
    .probe_level (probe_level),
    .map_vec     (map_vec),
    .tgt_lim     (tgt_n_q)
);

// File: tb/sgi_search_engine_bench.sv
// Self-checking bench: a table of graph-shape pairs with expected verdicts,
// walked in one loop, then directed tests for reset, pruning and corners.
module sgi_search_engine_bench;

    localparam int PA = 6;
    localparam int PB = 8;
    localparam int CW = $clog2(((PA > PB) ? PA : PB) + 1);
    localparam int LW = (PA > 1) ? $clog2(PA) : 1;

    localparam int SH_EMPTY = 0, SH_PATH = 1, SH_CYCLE = 2, SH_FULL = 3, SH_STAR = 4;

    typedef struct packed {
        logic [2:0] ps;
        logic [3:0] pn;
        logic [2:0] ts;
        logic [3:0] tn;
        logic       ex;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 4'd3, 3'd2, 4'd5, 1'b1},
        '{3'd3, 4'd3, 3'd2, 4'd5, 1'b0},
        '{3'd3, 4'd3, 3'd3, 4'd4, 1'b1},
        '{3'd2, 4'd4, 3'd3, 4'd4, 1'b1},
        '{3'd4, 4'd4, 3'd2, 4'd6, 1'b0},
        '{3'd3, 4'd4, 3'd2, 4'd4, 1'b0},
        '{3'd2, 4'd4, 3'd2, 4'd6, 1'b0},
        '{3'd1, 4'd4, 3'd4, 4'd5, 1'b0},
        '{3'd0, 4'd3, 3'd0, 4'd3, 1'b1},
        '{3'd1, 4'd6, 3'd2, 4'd8, 1'b1},
        '{3'd2, 4'd5, 3'd3, 4'd5, 1'b1},
        '{3'd4, 4'd3, 3'd1, 4'd3, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CW-1:0]    pat_n = '0;
    logic [CW-1:0]    tgt_n = '0;
    logic [PA*PA-1:0] pat_adj = '0;
    logic [PB*PB-1:0] tgt_adj = '0;
    logic             prune_ok;
    logic             busy, done, found, probe_valid;
    logic [LW-1:0]    probe_level;
    logic [PA*CW-1:0] map_vec;

    logic [1:0] pmode = 2'd0;
    int checks = 0;
    int errors = 0;
    int nodes, leaves, cyc;
    bit exp_found;
    int exp_map [PA];

    always #10 clk = ~clk;

    // Pruning stand-in: pass all, reject all, reject vertex 0 at level 0, reject leaves.
    assign prune_ok = (pmode == 2'd0) ? 1'b1 :
                      (pmode == 2'd1) ? 1'b0 :
                      (pmode == 2'd2) ? !((probe_level == '0) && (map_vec[CW-1:0] == '0)) :
                                        (CW'(probe_level) != (pat_n - 1'b1));

    sgi_search_engine #(.PA(PA), .PB(PB)) u_sgi_search_engine (
        .clk, .rst_n, .start, .pat_n, .tgt_n, .pat_adj, .tgt_adj, .prune_ok,
        .busy, .done, .found, .probe_valid, .probe_level, .map_vec
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit has_edge(input int shape, input int n, input int a, input int b);
        case (shape)
            SH_PATH:  return b == a + 1;
            SH_CYCLE: return (b == a + 1) || (n >= 3 && a == 0 && b == n - 1);
            SH_FULL:  return 1'b1;
            SH_STAR:  return a == 0;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [PB*PB-1:0] shape_adj(input int shape, input int n, input int stride);
        logic [PB*PB-1:0] m = '0;
        for (int a = 0; a < n; a++)
            for (int b = a + 1; b < n; b++)
                if (has_edge(shape, n, a, b)) begin
                    m[a*stride+b] = 1'b1;
                    m[b*stride+a] = 1'b1;
                end
        return m;
    endfunction

    function automatic int perm(input int n, input int k);
        int p = 1;
        for (int i = 0; i < k; i++) p = p * (n - i);
        return p;
    endfunction

    function automatic int field(input int k);
        return int'(map_vec[k*CW +: CW]);
    endfunction

    // Brute-force reference: lexicographically first injective edge-preserving map.
    task automatic reference(input int pn, input int tn);
        int total = 1;
        int d [PA];
        exp_found = 1'b0;
        for (int k = 0; k < PA; k++) exp_map[k] = 0;
        if (pn > tn) return;
        if (pn == 0) begin exp_found = 1'b1; return; end
        for (int k = 0; k < pn; k++) total = total * tn;
        for (int idx = 0; idx < total; idx++) begin
            int rem = idx;
            bit ok = 1'b1;
            for (int k = pn - 1; k >= 0; k--) begin
                d[k] = rem % tn;
                rem = rem / tn;
            end
            for (int a = 0; a < pn; a++)
                for (int b = a + 1; b < pn; b++) begin
                    if (d[a] == d[b]) ok = 1'b0;
                    if (pat_adj[a*PA+b] && !tgt_adj[d[a]*PB+d[b]]) ok = 1'b0;
                end
            if (ok) begin
                exp_found = 1'b1;
                for (int k = 0; k < pn; k++) exp_map[k] = d[k];
                return;
            end
        end
    endtask

    // Pulse start, then count nodes and leaves until done; optional start mid-run.
    task automatic run_search(input int inject);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        nodes = 0; leaves = 0; cyc = 0;
        while (!done && cyc < 20000) begin
            if (probe_valid) begin
                nodes++;
                if (CW'(probe_level) == pat_n - 1'b1) leaves++;
            end
            @(negedge clk);
            cyc++;
            start = (cyc == inject);
        end
        start = 1'b0;
    endtask

    task automatic load(input int ps, input int pn, input int ts, input int tn);
        pat_n   = CW'(pn);
        tgt_n   = CW'(tn);
        pat_adj = shape_adj(ps, pn, PA)[PA*PA-1:0];
        tgt_adj = shape_adj(ts, tn, PB);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !found && !busy && map_vec == '0, "R1", "reset outputs", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy && map_vec == '0, "R1", "idle after reset", int'(busy), 0);

        // Table walk: verdict, smallest mapping and exhaustive leaf count.
        for (int v = 0; v < NV; v++) begin
            pmode = 2'd0;
            load(int'(VEC[v].ps), int'(VEC[v].pn), int'(VEC[v].ts), int'(VEC[v].tn));
            reference(int'(VEC[v].pn), int'(VEC[v].tn));
            run_search(-1);
            check(done, "R3", $sformatf("vector %0d done", v), int'(done), 1);
            check(found == VEC[v].ex, "R3", $sformatf("vector %0d found", v), int'(found), int'(VEC[v].ex));
            if (VEC[v].ex) begin
                for (int k = 0; k < int'(VEC[v].pn); k++)
                    check(field(k) == exp_map[k], "R4", $sformatf("vector %0d field %0d", v, k),
                          field(k), exp_map[k]);
            end else begin
                check(leaves == perm(int'(VEC[v].tn), int'(VEC[v].pn)), "R5",
                      $sformatf("vector %0d leaves", v), leaves, perm(int'(VEC[v].tn), int'(VEC[v].pn)));
            end
        end

        // R6: larger pattern than target ends at once.
        load(SH_FULL, 5, SH_FULL, 4);
        run_search(-1);
        check(cyc == 0 && done && !found, "R6", "size reject timing", cyc, 0);
        check(!busy && nodes == 0, "R6", "size reject no search", nodes, 0);

        // R10: empty pattern is found at once.
        load(SH_EMPTY, 0, SH_PATH, 3);
        run_search(-1);
        check(cyc == 0 && done && found, "R10", "empty pattern", int'(found), 1);

        // R4 and R7: single edge into target edge {0,1}, with and without pruning vertex 0.
        load(SH_PATH, 2, SH_PATH, 2);
        tgt_n = CW'(3);
        run_search(-1);
        check(found && field(0) == 0 && field(1) == 1, "R4", "ascending order map", field(0), 0);
        pmode = 2'd2;
        run_search(-1);
        check(found && field(0) == 1 && field(1) == 0, "R7", "pruned level-0 map", field(0), 1);

        // R7: pruning vertex 0 at level 0 trims the leaf count.
        load(SH_PATH, 3, SH_EMPTY, 4);
        run_search(-1);
        check(!found && leaves == 18, "R7", "leaves with level-0 prune", leaves, 18);

        // R7: prune everything, so only the level-0 nodes appear.
        pmode = 2'd1;
        run_search(-1);
        check(!found && nodes == 4 && leaves == 0, "R7", "prune all nodes", nodes, 4);

        // R7: leaf-level prune blocks an otherwise certain match.
        pmode = 2'd3;
        load(SH_EMPTY, 3, SH_EMPTY, 3);
        run_search(-1);
        check(!found && leaves == 6, "R7", "leaf prune leaves", leaves, 6);

        // R8: a start during the search changes nothing.
        pmode = 2'd0;
        load(SH_PATH, 3, SH_EMPTY, 4);
        run_search(5);
        check(!found && leaves == 24, "R8", "start while busy", leaves, 24);

        // R9: result held while idle.
        load(SH_PATH, 3, SH_CYCLE, 5);
        run_search(-1);
        begin
            logic [PA*CW-1:0] held;
            held = map_vec;
            repeat (6) @(negedge clk);
            check(done && found && map_vec == held, "R9", "result held", int'(map_vec == held), 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule